// File: doc/BRIEF.md
# Fast Ethernet Transmit Symbol Path

This block turns a 2-bit-wide transmit stream into the three-level line code of a 100 Mb/s twisted-pair link. A source presents dibits with a transfer strobe and a frame qualifier. On average it delivers two dibits every five clocks, which is 50 M transfers per second against the single 125 MHz core clock. The block pairs the dibits into nibbles and buffers them in a small FIFO, which absorbs the rate mismatch and any burstiness of the strobe. Each nibble then becomes a 5-bit code group.

A framer wraps every frame in start and end delimiters and fills the line with idle groups between frames. The groups are shifted out one bit per clock and whitened by an 11-bit scrambler. The stream then goes through NRZI and MLT-3 coding. The NRZI bit and the MLT-3 level are both available as registered outputs: the first can drive an optical module, the second drives a twisted-pair line driver.

The frame qualifier marks the frame. The first octet of the frame, its first two nibbles, is sacrificed to the start delimiter, as the preamble allows. When the qualifier drops, the frame is closed after the last buffered nibble.

Top module: `fetx_symbol_path`

## Requirements
- R1: While reset is high and in the cycle after it, `mlt_code` is 2'b00 and `line_nrzi` is 0. After reset the line carries idle groups.
- R2: Outside frames, every code group sent is IDLE (11111), so the descrambled bit stream is all ones.
- R3: A frame begins when at least two nibbles are buffered. Its first two nibbles are not sent. In their place go J (11000) and then K (10001).
- R4: Dibits accepted with `tx_valid`=1 and `tx_en`=1 form nibbles, the first dibit becoming bits 1:0. From the third nibble on, each nibble is sent as its 4B/5B group (0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101). Each group goes out leftmost bit first.
- R5: When `tx_en` goes low, the remaining buffered nibbles are sent. They are followed by T (01101) and R (00111), and then idle.
- R6: If a frame ends with an odd number of dibits, the last dibit is sent as a nibble whose bits 3:2 are zero.
- R7: Each clock, the serial bit is XORed with the feedback bit of an 11-bit LFSR. The feedback bit is state[10] XOR state[8], and it is shifted into state[0]. The LFSR starts at the seed 11'h7FF after reset and advances every clock.
- R8: `line_nrzi` toggles exactly in the cycles where the scrambled bit is 1.
- R9: `mlt_code` uses 2'b01 for +1, 2'b00 for 0 and 2'b11 for -1. It changes only in a cycle where `line_nrzi` toggles, stepping through the cycle 0, +1, 0, -1. The first step after reset goes to +1.
- R10: If no nibble is buffered when a data group is due, the frame is closed with T and R. The end marker that arrives later produces no further output.
- R11: A code group starts every 5 clocks on a fixed grid. Steady and bursty strobe patterns with the same average rate produce identical frames, with no nibble lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz core clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Transfer strobe for `tx_dibit` |
| tx_en | input | 1 | Frame qualifier; high while the frame lasts |
| tx_dibit | input | 2 | Transmit data, two bits per transfer |
| line_nrzi | output | 1 | Registered NRZI serial bit |
| mlt_code | output | 2 | Registered MLT-3 level: 01 = +1, 00 = 0, 11 = -1 |

## Verification
The bench recovers the scrambled bits from transitions of `line_nrzi` and removes its own keystream. It then parses the code groups, so a wrong tap, seed, bit order or table entry shows up as a missing delimiter or a wrong nibble. It looks for the nibble lost at the odd-dibit boundary, for a frame that is left open when the FIFO runs dry, and for a stray frame caused by the late end marker. A two-nibble frame must show only J, K, T and R. Every output sample is compared with an MLT-3 model, so a design that took a shortcut from +1 to -1, or that stepped without an NRZI toggle, is caught. Feeding the same data with steady and with bursty strobes would expose a FIFO that drops or duplicates entries.

// File: rtl/fetx_pkg.sv
package fetx_pkg;
  localparam int SYM_W = 5;
  localparam int NIB_W = 4;
  localparam int DIB_W = 2;

  localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
  localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
  localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
  localparam logic [SYM_W-1:0] CG_R    = 5'b00111;

  typedef enum logic [1:0] {
    MLT_ZERO = 2'b00,
    MLT_POS  = 2'b01,
    MLT_NEG  = 2'b11
  } mlt_t;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_SEND_K,
    FR_DATA,
    FR_SEND_R
  } frame_st_t;

  typedef struct packed {
    logic             is_end;
    logic [NIB_W-1:0] nib;
  } fifo_word_t;

  function automatic logic [SYM_W-1:0] enc_4b5b(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] g;
    case (n)
      4'h0: g = 5'b11110;
      4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;
      4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;
      4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;
      4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;
      4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;
      4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;
      4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;
      default: g = 5'b11101;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/fetx_dibit_packer.sv
module fetx_dibit_packer
  import fetx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tx_valid,
  input  logic                 tx_en,
  input  logic [DIB_W-1:0]     tx_dibit,
  output logic                 push,
  output fifo_word_t           word
);
  logic             half_q;
  logic [DIB_W-1:0] low_q;
  logic             active_q;
  logic             end_pend_q;

  // First dibit of a pair lands in the low bits (R4); a lone last dibit
  // is padded with zeros (R6) and its end marker follows one clock later.
  always_ff @(posedge clk) begin
    if (rst) begin
      push       <= 1'b0;
      word       <= '0;
      half_q     <= 1'b0;
      low_q      <= '0;
      active_q   <= 1'b0;
      end_pend_q <= 1'b0;
    end else begin
      push <= 1'b0;
      if (end_pend_q) begin
        push       <= 1'b1;
        word       <= '{is_end: 1'b1, nib: '0};
        end_pend_q <= 1'b0;
        if (tx_valid && tx_en) begin
          low_q    <= tx_dibit;
          half_q   <= 1'b1;
          active_q <= 1'b1;
        end
      end else if (tx_valid && tx_en) begin
        active_q <= 1'b1;
        if (half_q) begin
          push   <= 1'b1;
          word   <= '{is_end: 1'b0, nib: {tx_dibit, low_q}};
          half_q <= 1'b0;
        end else begin
          low_q  <= tx_dibit;
          half_q <= 1'b1;
        end
      end else if (active_q && !tx_en) begin
        active_q <= 1'b0;
        push     <= 1'b1;
        half_q   <= 1'b0;
        if (half_q) begin
          word       <= '{is_end: 1'b0, nib: {{(NIB_W-DIB_W){1'b0}}, low_q}};
          end_pend_q <= 1'b1;
        end else begin
          word <= '{is_end: 1'b1, nib: '0};
        end
      end
    end
  end
endmodule

// File: rtl/fetx_fifo.sv
module fetx_fifo #(
  parameter int WIDTH = 5,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full,
  output logic [LW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [LW-1:0]    wr_q;
  logic [LW-1:0]    rd_q;

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_q[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push && !full) wr_q <= wr_q + 1'b1;
      if (pop && !empty) rd_q <= rd_q + 1'b1;
    end
  end

  assign rdata = mem[rd_q[AW-1:0]];
  assign level = wr_q - rd_q;
  assign empty = (wr_q == rd_q);
  assign full  = (level == LW'(DEPTH));
endmodule

// File: rtl/fetx_framer.sv
module fetx_framer
  import fetx_pkg::*;
#(
  parameter int LW          = 4,
  parameter int START_LEVEL = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_load,
  input  fifo_word_t       head,
  input  logic             empty,
  input  logic [LW-1:0]    level,
  output logic             pop,
  output logic [SYM_W-1:0] group
);
  frame_st_t st_q, st_d;
  logic      want_pop;

  always_comb begin
    st_d     = st_q;
    want_pop = 1'b0;
    group    = CG_IDLE;
    case (st_q)
      FR_IDLE: begin
        if (!empty && head.is_end) begin
          want_pop = 1'b1;                      // stale end marker (R10)
        end else if (!empty && level >= LW'(START_LEVEL)) begin
          want_pop = 1'b1;                      // first nibble -> J (R3)
          group    = CG_J;
          st_d     = FR_SEND_K;
        end
      end
      FR_SEND_K: begin
        group    = CG_K;
        want_pop = !empty && !head.is_end;
        st_d     = FR_DATA;
      end
      FR_DATA: begin
        if (empty) begin
          group = CG_T;                         // underflow close (R10)
          st_d  = FR_SEND_R;
        end else if (head.is_end) begin
          want_pop = 1'b1;
          group    = CG_T;
          st_d     = FR_SEND_R;
        end else begin
          want_pop = 1'b1;
          group    = enc_4b5b(head.nib);
        end
      end
      default: begin
        group = CG_R;
        st_d  = FR_IDLE;
      end
    endcase
  end

  assign pop = want_pop && sym_load;

  always_ff @(posedge clk) begin
    if (rst)           st_q <= FR_IDLE;
    else if (sym_load) st_q <= st_d;
  end
endmodule

// File: rtl/fetx_line_path.sv
module fetx_line_path
  import fetx_pkg::*;
#(
  parameter int          LFSR_W = 11,
  parameter int          TAP_HI = 10,
  parameter int          TAP_LO = 8,
  parameter logic [10:0] SEED   = 11'h7FF,
  localparam int         CW     = $clog2(SYM_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SYM_W-1:0]  group,
  output logic              sym_load,
  output logic              line_nrzi,
  output mlt_t              mlt_code,
  output logic [LFSR_W-1:0] lfsr_state
);
  logic [CW-1:0]    cnt_q;
  logic [SYM_W-1:0] sh_q;
  logic [LFSR_W-1:0] lfsr_q;
  logic             scr_q;
  logic             last_pos_q;
  logic             fb;

  assign sym_load   = (cnt_q == CW'(SYM_W - 1));
  assign fb         = lfsr_q[TAP_HI] ^ lfsr_q[TAP_LO];
  assign lfsr_state = lfsr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= CW'(SYM_W - 1);
      sh_q       <= CG_IDLE;
      lfsr_q     <= LFSR_W'(SEED);
      scr_q      <= 1'b0;
      line_nrzi  <= 1'b0;
      mlt_code   <= MLT_ZERO;
      last_pos_q <= 1'b0;
    end else begin
      cnt_q  <= sym_load ? '0 : cnt_q + 1'b1;
      sh_q   <= sym_load ? group : {sh_q[SYM_W-2:0], 1'b0};
      lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
      scr_q  <= sh_q[SYM_W-1] ^ fb;
      line_nrzi <= line_nrzi ^ scr_q;
      if (scr_q) begin
        case (mlt_code)
          MLT_ZERO: begin
            mlt_code   <= last_pos_q ? MLT_NEG : MLT_POS;
            last_pos_q <= !last_pos_q;
          end
          default: mlt_code <= MLT_ZERO;
        endcase
      end
    end
  end
endmodule

// File: rtl/fetx_symbol_path.sv
module fetx_symbol_path
  import fetx_pkg::*;
#(
  parameter int          FIFO_DEPTH  = 8,
  parameter int          START_LEVEL = 2,
  parameter logic [10:0] SEED        = 11'h7FF,
  localparam int         LW          = $clog2(FIFO_DEPTH) + 1,
  localparam int         FW          = $bits(fifo_word_t)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_valid,
  input  logic             tx_en,
  input  logic [DIB_W-1:0] tx_dibit,
  output logic             line_nrzi,
  output logic [1:0]       mlt_code
);
  logic             fifo_push;
  fifo_word_t       push_word;
  logic [FW-1:0]    head_raw;
  fifo_word_t       head_word;
  logic             fifo_pop;
  logic             fifo_empty;
  logic             fifo_full;
  logic [LW-1:0]    fifo_level;
  logic             sym_load;
  logic [SYM_W-1:0] next_group;
  logic [10:0]      lfsr_state;
  mlt_t             mlt_level;

  fetx_dibit_packer packer_i (
    .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_en(tx_en),
    .tx_dibit(tx_dibit), .push(fifo_push), .word(push_word)
  );

  fetx_fifo #(.WIDTH(FW), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .push(fifo_push), .wdata(push_word),
    .pop(fifo_pop), .rdata(head_raw), .empty(fifo_empty),
    .full(fifo_full), .level(fifo_level)
  );

  assign head_word = fifo_word_t'(head_raw);

  fetx_framer #(.LW(LW), .START_LEVEL(START_LEVEL)) framer_i (
    .clk(clk), .rst(rst), .sym_load(sym_load), .head(head_word),
    .empty(fifo_empty), .level(fifo_level), .pop(fifo_pop),
    .group(next_group)
  );

  fetx_line_path #(.SEED(SEED)) line_i (
    .clk(clk), .rst(rst), .group(next_group), .sym_load(sym_load),
    .line_nrzi(line_nrzi), .mlt_code(mlt_level), .lfsr_state(lfsr_state)
  );

  assign mlt_code = mlt_level;
endmodule

module fetx_symbol_path_chk (
  input logic        clk,
  input logic        rst,
  input logic        line_nrzi,
  input logic [1:0]  mlt_code,
  input logic        fifo_push,
  input logic        fifo_full,
  input logic        fifo_pop,
  input logic        fifo_empty,
  input logic        sym_load,
  input logic [10:0] lfsr_state
);
  assert_mlt_legal_R9: assert property (@(posedge clk) disable iff (rst)
    mlt_code != 2'b10);

  assert_mlt_needs_toggle_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(mlt_code) |-> (line_nrzi != $past(line_nrzi)));

  assert_mlt_via_zero_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(mlt_code) != 2'b00 && !$stable(mlt_code)) |-> mlt_code == 2'b00);

  assert_toggle_moves_mlt_R8: assert property (@(posedge clk) disable iff (rst)
    (line_nrzi != $past(line_nrzi)) |-> !$stable(mlt_code));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !fifo_push);

  assert_no_pop_empty_R10: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_empty);

  assert_load_spacing_R11: assert property (@(posedge clk) disable iff (rst)
    sym_load |=> !sym_load);

  assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (rst)
    lfsr_state != 11'h000);
endmodule

bind fetx_symbol_path fetx_symbol_path_chk chk_i (
  .clk(clk), .rst(rst), .line_nrzi(line_nrzi), .mlt_code(mlt_code),
  .fifo_push(fifo_push), .fifo_full(fifo_full), .fifo_pop(fifo_pop),
  .fifo_empty(fifo_empty), .sym_load(sym_load), .lfsr_state(lfsr_state)
);

// File: tb/fetx_symbol_path_tb_top.sv
`timescale 1ns/1ps
module fetx_symbol_path_tb_top;
  localparam int MAXS = 8192;
  localparam logic [10:0] SEED = 11'h7FF;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_valid = 1'b0;
  logic       tx_en = 1'b0;
  logic [1:0] tx_dibit = 2'b00;
  logic       line_nrzi;
  logic [1:0] mlt_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  bit         nz [MAXS];
  bit         key [MAXS];
  int         ns = 0;
  int         lag = -1;
  int         phase = -1;
  int         ptr = 20;
  int         mlt_err = 0;
  int         mlt_first_k = -1;
  logic [1:0] mlt_first_act, mlt_first_exp;

  int nib [256];
  int n_nib;
  int dib [512];
  int n_dib;
  int expn [256];
  int n_exp;

  always #2.5 clk = ~clk;

  fetx_symbol_path dut_i (
    .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_en(tx_en),
    .tx_dibit(tx_dibit), .line_nrzi(line_nrzi), .mlt_code(mlt_code)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // capture and MLT-3 model (R9)
  logic [1:0] m_lvl = 2'b00;
  bit         m_lastpos = 1'b0;
  bit         m_prevn = 1'b0;
  always @(negedge clk) begin
    if (!rst && ns < MAXS) begin
      logic [1:0] e;
      bit tog;
      nz[ns] = line_nrzi;
      tog = line_nrzi ^ m_prevn;
      e = m_lvl;
      if (tog) begin
        if (m_lvl == 2'b00) begin
          e = m_lastpos ? 2'b11 : 2'b01;
          m_lastpos = !m_lastpos;
        end else e = 2'b00;
      end
      if (mlt_code !== e) begin
        if (mlt_err == 0) begin
          mlt_first_k = ns; mlt_first_act = mlt_code; mlt_first_exp = e;
        end
        mlt_err++;
      end
      m_lvl = e;
      m_prevn = line_nrzi;
      ns++;
    end
  end

  function automatic bit plain(input int k);
    return (nz[k] ^ nz[k-1]) ^ key[k-lag];
  endfunction

  function automatic int grp(input int k);
    int g = 0;
    for (int i = 0; i < 5; i++) g = (g << 1) | int'(plain(k + i));
    return g;
  endfunction

  function automatic int dec4b5b(input int g);
    case (g)
      5'b11110: return 0;  5'b01001: return 1;  5'b10100: return 2;
      5'b10101: return 3;  5'b01010: return 4;  5'b01011: return 5;
      5'b01110: return 6;  5'b01111: return 7;  5'b10010: return 8;
      5'b10011: return 9;  5'b10110: return 10; 5'b10111: return 11;
      5'b11010: return 12; 5'b11011: return 13; 5'b11100: return 14;
      5'b11101: return 15; default: return -1;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic build_dibits(input int odd_dibit);
    n_dib = 0;
    for (int i = 0; i < n_nib; i++) begin
      dib[n_dib++] = nib[i] & 3;
      dib[n_dib++] = (nib[i] >> 2) & 3;
    end
    n_exp = 0;
    for (int i = 2; i < n_nib; i++) expn[n_exp++] = nib[i];
    if (odd_dibit >= 0) begin
      dib[n_dib++] = odd_dibit;
      expn[n_exp++] = odd_dibit;
    end
  endtask

  // mode 0: steady two-in-five, mode 1: bursts of four every ten clocks
  task automatic drive(input int mode, input int stall);
    tx_en = 1'b1;
    for (int i = 0; i < n_dib; i++) begin
      tx_valid = 1'b1;
      tx_dibit = 2'(dib[i]);
      tick(1);
      tx_valid = 1'b0;
      if (mode == 0) tick((i % 2 == 0) ? 1 : 2);
      else if (i % 4 == 3) tick(6);
    end
    if (stall > 0) tick(stall);
    tx_en = 1'b0;
    tick(1);
  endtask

  task automatic decode_frame(input string req);
    int z, js, k, i, g;
    bit closed;
    z = -1;
    for (int j = ptr; j < ns - 12; j++) if (!plain(j)) begin z = j; break; end
    chk(z >= 2, "R3", {req, " start delimiter present"}, z, 1);
    if (z < 2) return;
    js = z - 2;
    chk(grp(js) == 5'b11000 && grp(js + 5) == 5'b10001, "R3",
        {req, " J then K"}, (grp(js) << 5) | grp(js + 5), 10'b1100010001);
    if (phase < 0) phase = js % 5;
    else chk((js % 5) == phase, "R11", {req, " group grid"}, js % 5, phase);
    k = js + 10;
    i = 0;
    closed = 1'b0;
    for (int n = 0; n < 300 && k < ns - 10; n++) begin
      g = grp(k);
      if (g == 5'b01101) begin
        chk(grp(k + 5) == 5'b00111, "R5", {req, " R after T"}, grp(k + 5), 5'b00111);
        k += 10;
        closed = 1'b1;
        break;
      end
      if (i < n_exp)
        chk(dec4b5b(g) == expn[i], "R4", {req, " data nibble"}, dec4b5b(g), expn[i]);
      i++;
      k += 5;
    end
    chk(closed, "R5", {req, " frame closed by T"}, int'(closed), 1);
    chk(i == n_exp, "R4", {req, " data nibble count"}, i, n_exp);
    ptr = k;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    tick(4);
    chk(mlt_code == 2'b00, "R1", "mlt level in reset", mlt_code, 0);
    chk(line_nrzi == 1'b0, "R1", "nrzi in reset", line_nrzi, 0);
    rst = 1'b0;
    tick(1);
    chk(mlt_code == 2'b00 && line_nrzi == 1'b0, "R1", "outputs after reset",
        {mlt_code, line_nrzi}, 0);
  endtask

  task automatic t_align;
    bit ok;
    tick(300);
    for (int d = 0; d < 12 && lag < 0; d++) begin
      lag = d;
      ok = 1'b1;
      for (int k = 20; k < 280; k++) if (!plain(k)) ok = 1'b0;
      if (!ok) lag = -1;
    end
    chk(lag >= 0, "R7", "keystream from seed removes idle whitening (R8 nrzi)", lag, 1);
    if (lag < 0) lag = 1;
  endtask

  task automatic t_steady;
    n_nib = 18;
    nib[0] = 5; nib[1] = 5;
    for (int i = 2; i < n_nib; i++) nib[i] = (i * 3 + 1) & 15;
    build_dibits(-1);
    drive(0, 0);
    tick(100);
    decode_frame("R11 steady frame");
  endtask

  task automatic t_burst;
    n_nib = 18;
    nib[0] = 5; nib[1] = 13;
    for (int i = 2; i < n_nib; i++) nib[i] = i - 2;
    build_dibits(-1);
    drive(1, 0);
    tick(100);
    decode_frame("R11 burst frame");
  endtask

  task automatic t_odd;
    n_nib = 3;
    nib[0] = 5; nib[1] = 5; nib[2] = 9;
    build_dibits(2);
    drive(0, 0);
    tick(100);
    decode_frame("R6 odd dibit frame");
  endtask

  task automatic t_short;
    n_nib = 2;
    nib[0] = 5; nib[1] = 5;
    build_dibits(-1);
    drive(0, 0);
    tick(100);
    decode_frame("R5 two-nibble frame");
  endtask

  task automatic t_underflow;
    n_nib = 3;
    nib[0] = 5; nib[1] = 5; nib[2] = 12;
    build_dibits(-1);
    drive(0, 40);
    tick(100);
    decode_frame("R10 underflow frame");
  endtask

  task automatic t_tail;
    int bad = 0;
    tick(120);
    for (int k = ptr; k < ns; k++) if (!plain(k)) bad++;
    chk(bad == 0, "R2", "idle after last frame and no stray frame (R10)", bad, 0);
    chk(mlt_err == 0, "R9", "MLT-3 level sequence", mlt_err, 0);
    if (mlt_err != 0)
      $display("  first MLT mismatch at sample %0d: actual %0d expected %0d",
               mlt_first_k, mlt_first_act, mlt_first_exp);
  endtask

  initial begin
    logic [10:0] s = SEED;
    for (int j = 0; j < MAXS; j++) begin
      key[j] = s[10] ^ s[8];
      s = {s[9:0], key[j]};
    end
  end

  initial begin
    t_reset();
    t_align();
    t_steady();
    tick(20);
    t_burst();
    tick(20);
    t_odd();
    tick(20);
    t_short();
    tick(20);
    t_underflow();
    t_tail();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule